// File: doc/BRIEF.md
# Destructive-Read Memory with Mandatory Restore

This block models a small synchronous word store in which every read erases the word that it returns. A read captures the addressed word and writes zero into that location on the same clock edge. The caller must therefore write a value back before the block accepts a new address. The block sequences each access through fixed phases: address settling, reading, waiting for the restore, writing, and done. Each timed phase lasts for a number of clock cycles set by a parameter.

The read data appears on the output after its own output delay. This delay runs independently of the read-recovery delay that ends the reading phase. A strobe that arrives in a phase that does not accept it is ignored and sets a sticky error flag. A synchronous reset returns the block to idle, clears the flag and zeroes every word.

Top module: `drm_restore_mem`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge `state_o` is 0, `err_o` is 0 and `rd_data_o` is 0, and every word reads back as zero.
- R2: `addr_ld_i` is accepted in idle (0) or done (5). `state_o` is then 1 for exactly `T_ADDR` cycles, and then 0.
- R3: `rd_i` is accepted only in idle. The read returns the word stored at the loaded address, and that location holds zero from the same edge onward.
- R4: A location that has not been written since reset reads as zero.
- R5: `rd_data_o` takes the captured word exactly `T_OUT` cycles after the read edge. At every other edge it holds its value.
- R6: `state_o` is 2 for exactly `T_RREC` cycles after a read, and then 3. This holds regardless of `T_OUT`.
- R7: `wr_i` is accepted only in state 3. It stores `wr_data_i` at the loaded address. `state_o` is then 4 for `T_WDONE` cycles, and then 5.
- R8: A single strobe that the current state does not accept sets `err_o`, which stays high until reset. The strobe changes no state, stored word or address.
- R9: Two or more strobes in the same cycle set `err_o`, and all of them are ignored.
- R10: State 5 is left only by an address load. A read or a write in state 5 is a protocol error.
- R11: `busy_o` is high exactly in states 1, 2 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | AW | Address, captured on an accepted load |
| addr_ld_i | input | 1 | Address load strobe |
| rd_i | input | 1 | Destructive read strobe |
| wr_i | input | 1 | Restore write strobe |
| wr_data_i | input | DW | Data stored on an accepted write |
| rd_data_o | output | DW | Delayed read data |
| state_o | output | 3 | Phase: 0 idle, 1 address, 2 reading, 3 awaiting restore, 4 writing, 5 done |
| busy_o | output | 1 | A timed phase is in progress |
| err_o | output | 1 | Sticky protocol error |

## Verification
The bench uses an output delay longer than the read recovery. A design that tied the data output to the end of the reading phase would show the new word one cycle early, while the state is already 3. An address load issued while the block waits for the restore is checked through the next read. If the design took that load, the next read would return the wrong word. A load and a read in the same idle cycle must change nothing. A design that gave one of them priority would leave idle or move the address.

After a reset the bench reads a location that was written earlier and expects zero. It also issues a strobe during the reading phase and expects the phase timing to be unchanged. A design that restarted its phase counter on any strobe would stay in state 2 too long.

// File: rtl/drm_pkg.sv
package drm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ADDR  = 3'd1,
    ST_READ  = 3'd2,
    ST_PEND  = 3'd3,
    ST_WRITE = 3'd4,
    ST_DONE  = 3'd5
  } drm_state_e;

  typedef enum logic [1:0] {
    SK_LOAD  = 2'd0,
    SK_READ  = 2'd1,
    SK_WRITE = 2'd2
  } strobe_kind_e;

  // Delays below one cycle are raised to one.
  function automatic int clamp_delay(input int t);
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Counter width able to hold (max_delay - 1), at least one bit.
  function automatic int count_width(input int max_delay);
    return (max_delay < 2) ? 1 : $clog2(max_delay);
  endfunction

  // Which phase accepts which strobe.
  function automatic logic strobe_allowed(input drm_state_e s, input strobe_kind_e k);
    case (k)
      SK_LOAD:  return (s == ST_IDLE) || (s == ST_DONE);
      SK_READ:  return (s == ST_IDLE);
      default:  return (s == ST_PEND);
    endcase
  endfunction

  function automatic logic phase_is_timed(input drm_state_e s);
    return (s == ST_ADDR) || (s == ST_READ) || (s == ST_WRITE);
  endfunction

endpackage

// File: rtl/drm_phase_timer.sv
module drm_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - CW'(1);
    end
  end

  assign done_o = run_q && (cnt_q == '0);

  AST_TIMER_COUNTS_DOWN: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R6

  AST_TIMER_STOPS: assert property (@(posedge clk) disable iff (rst)
    (done_o && !load_i) |=> !run_q); // R5

endmodule

// File: rtl/drm_store.sv
module drm_store #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_clr_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem_q [DEPTH];
  logic [DEPTH-1:0] hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hit[g] = (addr_i == AW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit[i] && (rd_clr_i || wr_i)) mem_q[i] <= wr_i ? wdata_i : '0;
      end
    end
  end

  assign rdata_o = mem_q[addr_i];

  AST_READ_ERASES: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && !wr_i) |=> (mem_q[$past(addr_i)] == '0)); // R3

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (rst)
    !(rd_clr_i && wr_i)); // R9

endmodule

// File: rtl/drm_seq.sv
module drm_seq
  import drm_pkg::*;
#(
  parameter int CW       = 2,
  parameter int LV_ADDR  = 1,
  parameter int LV_READ  = 1,
  parameter int LV_WRITE = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          phase_done_i,
  output drm_state_e    state_o,
  output logic          phase_load_o,
  output logic [CW-1:0] phase_val_o,
  output logic          ld_fire_o,
  output logic          rd_fire_o,
  output logic          wr_fire_o,
  output logic          err_o
);

  drm_state_e state_q, state_d;
  logic       err_q;
  logic [1:0] n_strobes;
  logic       multi, any_strobe, bad_strobe;

  assign n_strobes  = {1'b0, ld_i} + {1'b0, rd_i} + {1'b0, wr_i};
  assign multi      = n_strobes > 2'd1;
  assign any_strobe = n_strobes != 2'd0;

  assign ld_fire_o  = ld_i && !multi && strobe_allowed(state_q, SK_LOAD);
  assign rd_fire_o  = rd_i && !multi && strobe_allowed(state_q, SK_READ);
  assign wr_fire_o  = wr_i && !multi && strobe_allowed(state_q, SK_WRITE);
  assign bad_strobe = any_strobe && !(ld_fire_o || rd_fire_o || wr_fire_o);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (ld_fire_o)      state_d = ST_ADDR;
        else if (rd_fire_o) state_d = ST_READ;
      end
      ST_ADDR:  if (phase_done_i) state_d = ST_IDLE;
      ST_READ:  if (phase_done_i) state_d = ST_PEND;
      ST_PEND:  if (wr_fire_o)    state_d = ST_WRITE;
      ST_WRITE: if (phase_done_i) state_d = ST_DONE;
      ST_DONE:  if (ld_fire_o)    state_d = ST_ADDR;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    phase_load_o = ld_fire_o || rd_fire_o || wr_fire_o;
    if (ld_fire_o)      phase_val_o = CW'(LV_ADDR);
    else if (rd_fire_o) phase_val_o = CW'(LV_READ);
    else                phase_val_o = CW'(LV_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (bad_strobe) err_q <= 1'b1;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R8

  AST_IGNORED_STROBE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (bad_strobe && !phase_done_i) |=> (state_q == $past(state_q))); // R8

  AST_MULTI_FLAGS: assert property (@(posedge clk) disable iff (rst)
    multi |=> err_q); // R9

  AST_READ_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && $past(state_q) != ST_READ) |-> ($past(state_q) == ST_IDLE)); // R3

  AST_WRITE_FROM_PEND: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WRITE && $past(state_q) != ST_WRITE) |-> ($past(state_q) == ST_PEND)); // R7

  AST_DONE_EXIT_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) == ST_DONE && state_q != ST_DONE) |-> (state_q == ST_ADDR)); // R10

endmodule

// File: rtl/drm_restore_mem.sv
module drm_restore_mem
  import drm_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DW      = 8,
  parameter int T_ADDR  = 2,
  parameter int T_OUT   = 3,
  parameter int T_RREC  = 2,
  parameter int T_WDONE = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_ld_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic [2:0]    state_o,
  output logic          busy_o,
  output logic          err_o
);

  localparam int TA_E  = clamp_delay(T_ADDR);
  localparam int TO_E  = clamp_delay(T_OUT);
  localparam int TR_E  = clamp_delay(T_RREC);
  localparam int TW_E  = clamp_delay(T_WDONE);
  localparam int MAX_T = max4(TA_E, TO_E, TR_E, TW_E);
  localparam int CW    = count_width(MAX_T);

  drm_state_e    state;
  logic          phase_load, phase_done, out_done;
  logic [CW-1:0] phase_val;
  logic          ld_fire, rd_fire, wr_fire;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] word_rd, hold_q, dout_q;

  drm_seq #(
    .CW(CW), .LV_ADDR(TA_E - 1), .LV_READ(TR_E - 1), .LV_WRITE(TW_E - 1)
  ) u_seq (
    .clk(clk), .rst(rst), .ld_i(addr_ld_i), .rd_i(rd_i), .wr_i(wr_i),
    .phase_done_i(phase_done), .state_o(state), .phase_load_o(phase_load),
    .phase_val_o(phase_val), .ld_fire_o(ld_fire), .rd_fire_o(rd_fire),
    .wr_fire_o(wr_fire), .err_o(err_o)
  );

  drm_phase_timer #(.CW(CW)) u_phase_tmr (
    .clk(clk), .rst(rst), .load_i(phase_load), .load_val_i(phase_val),
    .done_o(phase_done)
  );

  drm_phase_timer #(.CW(CW)) u_out_tmr (
    .clk(clk), .rst(rst), .load_i(rd_fire), .load_val_i(CW'(TO_E - 1)),
    .done_o(out_done)
  );

  drm_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .addr_i(addr_q), .rd_clr_i(rd_fire),
    .wr_i(wr_fire), .wdata_i(wr_data_i), .rdata_o(word_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      hold_q <= '0;
      dout_q <= '0;
    end else begin
      if (ld_fire)  addr_q <= addr_i;
      if (rd_fire)  hold_q <= word_rd;
      if (out_done) dout_q <= hold_q;
    end
  end

  assign rd_data_o = dout_q;
  assign state_o   = state;
  assign busy_o    = phase_is_timed(state);

  AST_DOUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_done |=> $stable(rd_data_o)); // R5

  AST_ADDR_ONLY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    !ld_fire |=> $stable(addr_q)); // R8

endmodule

// File: tb/drm_restore_mem_bench.sv
module drm_restore_mem_bench;

  localparam int AW = 4, DW = 8, TA = 2, TO = 3, TR = 2, TW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic ld = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [2:0]    st;
  logic          busy, err;

  int checks = 0, fails = 0;
  logic [DW-1:0] prev_out = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  drm_restore_mem #(
    .AW(AW), .DW(DW), .T_ADDR(TA), .T_OUT(TO), .T_RREC(TR), .T_WDONE(TW)
  ) u_drm_restore_mem (
    .clk(clk), .rst(rst), .addr_i(addr), .addr_ld_i(ld), .rd_i(rd), .wr_i(wr),
    .wr_data_i(wdata), .rd_data_o(rdata), .state_o(st), .busy_o(busy), .err_o(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic l, input logic r, input logic w,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    ld = l; rd = r; wr = w; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    ld = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic do_load(input logic [AW-1:0] a);
    pulse(1, 0, 0, a, '0);
    for (int c = 0; c <= TA; c++) begin
      if (c > 0) step(1);
      chk("R2 address phase state", st, (c < TA) ? 1 : 0);
      chk("R11 busy in address phase", busy, (c < TA) ? 1 : 0);
    end
  endtask

  task automatic do_read(input logic [DW-1:0] exp);
    int n;
    n = (TO > TR) ? TO : TR;
    pulse(0, 1, 0, '0, '0);
    for (int c = 0; c <= n; c++) begin
      if (c > 0) step(1);
      chk("R6 reading phase state", st, (c < TR) ? 2 : 3);
      chk("R11 busy in reading", busy, (c < TR) ? 1 : 0);
      chk("R5 output delay", rdata, (c < TO) ? prev_out : exp);
    end
    prev_out = exp;
  endtask

  task automatic do_write(input logic [DW-1:0] d);
    pulse(0, 0, 1, '0, d);
    for (int c = 0; c <= TW; c++) begin
      if (c > 0) step(1);
      chk("R7 write phase state", st, (c < TW) ? 4 : 5);
      chk("R11 busy in writing", busy, (c < TW) ? 1 : 0);
    end
  endtask

  task automatic t_reset;
    chk("R1 state after reset", st, 0);
    chk("R1 err after reset", err, 0);
    chk("R1 data after reset", rdata, 0);
    chk("R11 idle not busy", busy, 0);
  endtask

  task automatic t_fresh_and_restore;
    do_load(4'd5);
    do_read(8'h00);
    chk("R4 unwritten word is zero", rdata, 8'h00);
    do_write(8'hA5);
    do_load(4'd5);
    do_read(8'hA5);
    chk("R3 read returns stored word", rdata, 8'hA5);
    do_write(8'h5A);
    do_load(4'd5);
    do_read(8'h5A);
    chk("R7 restored value read back", rdata, 8'h5A);
    do_write(8'h11);
    do_load(4'd9);
    do_read(8'h00);
    chk("R4 other location still zero", rdata, 8'h00);
    do_write(8'h3C);
    do_load(4'd5);
    do_read(8'h11);
    chk("R7 neighbour write kept word", rdata, 8'h11);
    do_write(8'h11);
    chk("R8 no error in legal traffic", err, 0);
  endtask

  task automatic t_illegal;
    pulse(0, 1, 0, '0, '0);
    chk("R10 read in done flags error", err, 1);
    chk("R10 read in done ignored", st, 5);
    pulse(0, 0, 1, '0, 8'hEE);
    chk("R10 write in done ignored", st, 5);
    do_load(4'd9);
    pulse(0, 0, 1, '0, 8'hFF);
    chk("R8 write in idle ignored", st, 0);
    chk("R8 error stays set", err, 1);
    do_read(8'h3C);
    pulse(1, 0, 0, 4'd2, '0);
    chk("R8 load while pending ignored", st, 3);
    do_write(8'h3C);
    do_load(4'd9);
    do_read(8'h3C);
    chk("R8 ignored load kept address", rdata, 8'h3C);
    do_write(8'h3C);
  endtask

  task automatic t_reset_mid;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    prev_out = '0;
    chk("R1 err cleared by reset", err, 0);
    chk("R1 state idle after reset", st, 0);
    chk("R1 data zero after reset", rdata, 0);
    do_load(4'd9);
    pulse(0, 1, 0, '0, '0);
    pulse(1, 0, 0, 4'd1, '0);
    chk("R8 load during reading flags error", err, 1);
    chk("R6 reading phase unaffected", st, (TR > 1) ? 2 : 3);
    step(((TO > TR) ? TO : TR) - 1);
    chk("R6 pending after recovery", st, 3);
    chk("R1 memory zeroed by reset", rdata, 8'h00);
    prev_out = 8'h00;
    do_write(8'h77);
  endtask

  task automatic t_multi;
    rst = 1'b1;
    step(2);
    rst = 1'b0;
    prev_out = '0;
    do_load(4'd4);
    do_read(8'h00);
    do_write(8'h42);
    do_load(4'd4);
    pulse(1, 1, 0, 4'd7, '0);
    chk("R9 simultaneous strobes flag error", err, 1);
    chk("R9 simultaneous strobes ignored", st, 0);
    do_read(8'h42);
    chk("R9 address unchanged", rdata, 8'h42);
    do_write(8'h42);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    t_reset();
    t_fresh_and_restore();
    t_illegal();
    t_reset_mid();
    t_multi();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule